// File: doc/BRIEF.md
# Counting Bloom Filter Snoop Filter

This block keeps an approximate record of the cache-line addresses that belong to a set, so that a bus segment can skip snoops for lines that it cannot hold. It has two independent arrays of saturating counters. Each array is indexed by a hash of its own half of the line address. Inserting a line raises the indexed counter in both arrays, and removing a line lowers them. A line counts as possibly present only when both indexed counters are non-zero.

A query may return a false positive but never a false negative. There is no false negative for any line that was inserted and not yet removed. Three operations may be presented in one cycle, each with its own strobe and address: insert, remove and query. The query answer is registered and comes with a valid pulse.

Top module: `cbf_snoop_filter`

## Requirements
- R1: A synchronous reset clears every counter in both arrays to zero. While reset is held and in the cycle after it, `hit_valid` and `hit` are 0, so a query after reset misses every address.
- R2: Array A is indexed by the XOR of the 6-bit chunks of address bits [15:0], where the top chunk (bits [15:12]) is zero-padded. Array B uses the same fold on address bits [31:16]. Two addresses with equal indexes in both arrays are therefore indistinguishable.
- R3: An insert increments the indexed counter in both arrays. A later query of the same address reports a hit.
- R4: A remove decrements the indexed counter in both arrays. After as many removes as inserts, the address misses, provided no other live address shares its indexes.
- R5: A query hits only when both indexed counters are non-zero. An address whose A index matches a live entry but whose B index does not will miss.
- R6: The counters are 10 bits wide and hold at 1023 on increment. A counter at 1023 is never decremented, so removes cannot turn it into a miss.
- R7: A remove of a counter that is zero leaves it at zero. One later insert of that address then gives a hit.
- R8: If an insert and a remove address the same counter in the same cycle, that counter is unchanged.
- R9: `hit_valid` is high exactly one cycle after `qry_valid`, with `hit` valid in that cycle. A query reads the counters as they were before the updates of its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ins_valid | input | 1 | Insert strobe |
| ins_addr | input | 32 | Line address to insert |
| rem_valid | input | 1 | Remove strobe |
| rem_addr | input | 32 | Line address to remove |
| qry_valid | input | 1 | Query strobe |
| qry_addr | input | 32 | Line address to query |
| hit_valid | output | 1 | Query result valid, one cycle after the query |
| hit | output | 1 | Address may be present |

## Verification
An insert and a remove can fall in the same cycle, and a query can share that cycle with either of them. The bench drives an insert and a remove of the same address together, then queries the address and expects a hit, which shows the counter kept its value of one. A later single remove must then give a miss. It also issues a query in the same cycle as the first insert of an address and expects a miss, because the query sees the state from before the update, and then expects a hit on the next query.

// File: rtl/cbf_snoop_filter.sv
module cbf_snoop_filter #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              rem_valid,
  input  logic [ADDR_W-1:0] rem_addr,
  input  logic              qry_valid,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic              hit_valid,
  output logic              hit
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int HALF  = ADDR_W / 2;
  localparam logic [CNT_W-1:0] CMAX = '1;

  function automatic logic [IDX_W-1:0] fold(input logic [HALF-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < HALF; i++) r[i % IDX_W] ^= v[i];
    return r;
  endfunction

  logic [CNT_W-1:0] cnt [2][DEPTH];
  logic [IDX_W-1:0] ins_idx [2];
  logic [IDX_W-1:0] rem_idx [2];
  logic [IDX_W-1:0] qry_idx [2];

  assign ins_idx[0] = fold(ins_addr[HALF-1:0]);
  assign ins_idx[1] = fold(ins_addr[2*HALF-1:HALF]);
  assign rem_idx[0] = fold(rem_addr[HALF-1:0]);
  assign rem_idx[1] = fold(rem_addr[2*HALF-1:HALF]);
  assign qry_idx[0] = fold(qry_addr[HALF-1:0]);
  assign qry_idx[1] = fold(qry_addr[2*HALF-1:HALF]);

  for (genvar k = 0; k < 2; k++) begin : g_arr
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic inc, dec;
      assign inc = ins_valid && (ins_idx[k] == IDX_W'(e));
      assign dec = rem_valid && (rem_idx[k] == IDX_W'(e));
      always_ff @(posedge clk) begin
        if (rst)
          cnt[k][e] <= '0;
        else if (inc && !dec && cnt[k][e] != CMAX)
          cnt[k][e] <= cnt[k][e] + 1'b1;
        else if (dec && !inc && cnt[k][e] != '0 && cnt[k][e] != CMAX)
          cnt[k][e] <= cnt[k][e] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_valid <= 1'b0;
      hit       <= 1'b0;
    end else begin
      hit_valid <= qry_valid;
      hit       <= qry_valid && (cnt[0][qry_idx[0]] != '0) && (cnt[1][qry_idx[1]] != '0);
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!hit_valid && !hit && cnt[0][0] == '0 && cnt[1][0] == '0));

  assert_result_timing_R9: assert property (@(posedge clk) disable iff (rst)
    qry_valid |=> hit_valid);

  assert_no_stray_valid_R9: assert property (@(posedge clk) disable iff (rst)
    !qry_valid |=> (!hit_valid && !hit));

  assert_insert_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && !(rem_valid && rem_idx[0] == ins_idx[0]))
      |=> cnt[0][$past(ins_idx[0])] != '0);

  assert_saturated_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (rem_valid && cnt[1][rem_idx[1]] == CMAX) |=> cnt[1][$past(rem_idx[1])] == CMAX);

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    (rem_valid && cnt[0][rem_idx[0]] == '0 && !(ins_valid && ins_idx[0] == rem_idx[0]))
      |=> cnt[0][$past(rem_idx[0])] == '0);

  assert_cancel_R8: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && rem_valid && ins_idx[0] == rem_idx[0])
      |=> cnt[0][$past(ins_idx[0])] == $past(cnt[0][ins_idx[0]]));
endmodule

// File: tb/cbf_snoop_filter_tb.sv
module cbf_snoop_filter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ins_valid = 1'b0, rem_valid = 1'b0, qry_valid = 1'b0;
  logic [31:0] ins_addr = '0, rem_addr = '0, qry_addr = '0;
  logic        hit_valid, hit;
  int          checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbf_snoop_filter dut_i (
    .clk(clk), .rst(rst),
    .ins_valid(ins_valid), .ins_addr(ins_addr),
    .rem_valid(rem_valid), .rem_addr(rem_addr),
    .qry_valid(qry_valid), .qry_addr(qry_addr),
    .hit_valid(hit_valid), .hit(hit)
  );

  function automatic logic [5:0] ref_fold(input logic [15:0] v);
    logic [17:0] w;
    w = {2'b00, v};
    return w[5:0] ^ w[11:6] ^ w[17:12];
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic op(input logic i, input logic [31:0] ia,
                    input logic r, input logic [31:0] ra,
                    input logic q, input logic [31:0] qa);
    ins_valid = i; ins_addr = ia;
    rem_valid = r; rem_addr = ra;
    qry_valid = q; qry_addr = qa;
    @(negedge clk);
    ins_valid = 1'b0; rem_valid = 1'b0; qry_valid = 1'b0;
  endtask

  task automatic query(input string req, input logic [31:0] a, input logic exp);
    op(1'b0, '0, 1'b0, '0, 1'b1, a);
    check({req, " valid"}, hit_valid, 1'b1);
    check(req, hit, exp);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 hit_valid after reset", hit_valid, 1'b0);
    op(1'b1, 32'h1234_5678, 1'b0, '0, 1'b0, '0);
    do_reset();
    query("R1 miss after reset", 32'h1234_5678, 1'b0);
  endtask

  task automatic t_insert_remove();
    do_reset();
    op(1'b1, 32'h0000_0003, 1'b0, '0, 1'b0, '0);
    op(1'b1, 32'h0000_0003, 1'b0, '0, 1'b0, '0);
    query("R3 hit after insert", 32'h0000_0003, 1'b1);
    op(1'b0, '0, 1'b1, 32'h0000_0003, 1'b0, '0);
    query("R4 hit after one of two removes", 32'h0000_0003, 1'b1);
    op(1'b0, '0, 1'b1, 32'h0000_0003, 1'b0, '0);
    query("R4 miss after all removes", 32'h0000_0003, 1'b0);
  endtask

  task automatic t_hash();
    logic [31:0] alias_a;
    do_reset();
    alias_a = 32'h0041_0041;
    check("R2 reference alias", (ref_fold(alias_a[15:0]) == 6'd0) && (ref_fold(alias_a[31:16]) == 6'd0), 1'b1);
    op(1'b1, 32'h0000_0000, 1'b0, '0, 1'b0, '0);
    query("R2 alias false positive", alias_a, 1'b1);
    query("R2 one-bit different miss", 32'h0000_0040, 1'b0);
    query("R5 A match B differs miss", 32'h0001_0000, 1'b0);
    query("R5 B match A differs miss", 32'h0000_0001, 1'b0);
  endtask

  task automatic t_saturate();
    do_reset();
    for (int n = 0; n < 1030; n++) op(1'b1, 32'h0005_0005, 1'b0, '0, 1'b0, '0);
    for (int n = 0; n < 1100; n++) op(1'b0, '0, 1'b1, 32'h0005_0005, 1'b0, '0);
    query("R6 saturated counter holds", 32'h0005_0005, 1'b1);
    do_reset();
    for (int n = 0; n < 1000; n++) op(1'b1, 32'h0006_0006, 1'b0, '0, 1'b0, '0);
    for (int n = 0; n < 1000; n++) op(1'b0, '0, 1'b1, 32'h0006_0006, 1'b0, '0);
    query("R6 unsaturated counter drains", 32'h0006_0006, 1'b0);
  endtask

  task automatic t_underflow();
    do_reset();
    op(1'b0, '0, 1'b1, 32'h0007_0007, 1'b0, '0);
    op(1'b1, 32'h0007_0007, 1'b0, '0, 1'b0, '0);
    query("R7 no underflow", 32'h0007_0007, 1'b1);
  endtask

  task automatic t_cancel();
    do_reset();
    op(1'b1, 32'h0009_0009, 1'b0, '0, 1'b0, '0);
    op(1'b1, 32'h0009_0009, 1'b1, 32'h0009_0009, 1'b0, '0);
    query("R8 cancel keeps count", 32'h0009_0009, 1'b1);
    op(1'b0, '0, 1'b1, 32'h0009_0009, 1'b0, '0);
    query("R8 single remove clears", 32'h0009_0009, 1'b0);
  endtask

  task automatic t_timing();
    do_reset();
    op(1'b1, 32'h000A_000A, 1'b0, '0, 1'b1, 32'h000A_000A);
    check("R9 valid one cycle later", hit_valid, 1'b1);
    check("R9 query sees pre-update state", hit, 1'b0);
    @(negedge clk);
    check("R9 valid is a pulse", hit_valid, 1'b0);
    query("R9 later query hits", 32'h000A_000A, 1'b1);
  endtask

  initial begin
    t_reset();
    t_insert_remove();
    t_hash();
    t_saturate();
    t_underflow();
    t_cancel();
    t_timing();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule